// File: doc/BRIEF.md
# Interrupt Vector Gate Lookup

This block resolves an 8-bit interrupt vector to its gate descriptor. The vector is scaled by eight to give a byte offset into a single interrupt table. The offset is checked against the table limit. The block then reads the 8-byte descriptor as two 32-bit words over a valid/ready read port, and reports the handler entry point (a 16-bit target selector and a 32-bit offset) together with the kind of gate.

The table base and limit sit in an on-chip register. Software loads it through a 16-bit port as three consecutive words. A lookup whose descriptor would extend past the limit raises a fault that carries the vector, and issues no memory read. A descriptor whose type code is not a known gate raises a separate type error instead of a completion. Privilege checks, task switching and the control transfer itself are left to the surrounding logic.

Top module: `vec_gate_lookup`

## Requirements
- R1: After reset, `req_ready_o` is 1; `mem_valid_o`, `done_o`, `type_err_o` and `fault_o` are 0; the table limit and base are both 0, so a lookup of vector 0 faults.
- R2: The table register takes three `tbl_wr_i` words in a fixed sequence: the limit, then base bits 15:0, then base bits 31:16. The fourth write starts the sequence again with the limit.
- R3: The byte offset is the vector shifted left by 3. The first read goes to base + offset and the second read goes to base + offset + 4.
- R4: If offset + 7 > limit, `fault_o` pulses for one cycle with `fault_vec_o` equal to the vector, and no memory read is issued.
- R5: A descriptor whose last byte falls exactly on the limit (offset + 7 == limit) is looked up normally. This includes vector 255 at offset 2040 with limit 2047.
- R6: `mem_valid_o` stays high with a stable `mem_addr_o` until `mem_ready_i`. Each read word is taken on `mem_rvalid_i`, and a result follows only after the second word has arrived.
- R7: `gate_sel_o` = word0[31:16], and `gate_off_o` = {word1[31:16], word0[15:0]}.
- R8: The type code is word1[11:8]. Code 5 gives kind 0 (task), 6 or 14 give kind 1 (interrupt), and 7 or 15 give kind 2 (trap). A recognised code pulses `done_o` for one cycle.
- R9: Any other type code pulses `type_err_o` for one cycle, and `done_o` stays 0.
- R10: Vectors 0 to 31 are looked up exactly like any other vector.
- R11: `req_ready_o` is 0 from acceptance until the lookup ends. At most one of `done_o`, `type_err_o` and `fault_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tbl_wr_i | input | 1 | Table register word strobe |
| tbl_word_i | input | 16 | Table register word |
| req_valid_i | input | 1 | Lookup request |
| req_vec_i | input | 8 | Interrupt vector |
| req_ready_o | output | 1 | Block idle, request accepted |
| mem_valid_o | output | 1 | Read request valid |
| mem_addr_o | output | 32 | Read byte address |
| mem_ready_i | input | 1 | Read request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| done_o | output | 1 | Lookup completed with a valid gate |
| type_err_o | output | 1 | Descriptor type code not a gate |
| fault_o | output | 1 | Limit violation |
| fault_vec_o | output | 8 | Vector of the last lookup |
| gate_sel_o | output | 16 | Handler target selector |
| gate_off_o | output | 32 | Handler entry offset |
| gate_kind_o | output | 2 | 0 task, 1 interrupt, 2 trap |

## Verification
The lookup is driven with vectors at the two ends of the table and inside the exception range. Each is set against limits that sit exactly on, one entry below, and far below the descriptor's last byte, which separates an off-by-seven limit compare from a correct one. Descriptors carry distinct selector and offset halves, so a swapped or misplaced field shows up. Every type code class is covered, including codes that must be rejected. Memory responses use both zero and several cycles of grant delay and latency, and a reload with a new unaligned base exposes a wrong word order in the table register.

// File: rtl/vec_lookup_pkg.sv
package vec_lookup_pkg;
  typedef enum logic [1:0] {
    GK_TASK = 2'd0,
    GK_INT  = 2'd1,
    GK_TRAP = 2'd2,
    GK_NONE = 2'd3
  } gate_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_A0, ST_D0, ST_A1, ST_D1, ST_FIN, ST_FLT
  } lk_state_e;
endpackage

// File: rtl/vec_tbl_reg.sv
module vec_tbl_reg #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [ADDR_W-1:0] base_o,
  output logic [WORD_W-1:0] limit_o
);
  localparam int NB    = (ADDR_W + WORD_W - 1) / WORD_W;
  localparam int NW    = NB + 1;
  localparam int PTR_W = $clog2(NW);

  logic [PTR_W-1:0]       ptr_q;
  logic [NB*WORD_W-1:0]   base_q;
  logic [WORD_W-1:0]      limit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      base_q  <= '0;
      limit_q <= '0;
    end else if (wr_i) begin
      // word 0 is the limit, then base chunks low to high
      if (ptr_q == '0) limit_q <= word_i;
      for (int k = 0; k < NB; k++)
        if (ptr_q == PTR_W'(k + 1)) base_q[k*WORD_W +: WORD_W] <= word_i;
      ptr_q <= (ptr_q == PTR_W'(NW - 1)) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  assign base_o  = base_q[ADDR_W-1:0];
  assign limit_o = limit_q;
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8,
  parameter int LIM_W  = 16
) (
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LIM_W-1:0]  limit_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o
);
  localparam int DESC_SH = 3;
  localparam int OFF_W   = VEC_W + DESC_SH;

  logic [OFF_W-1:0] off;
  logic [LIM_W:0]   last_byte;

  assign off       = {vec_i, {DESC_SH{1'b0}}};
  assign last_byte = (LIM_W+1)'(off) + (LIM_W+1)'((1 << DESC_SH) - 1);
  assign fault_o   = last_byte > {1'b0, limit_i};
  assign addr_o    = base_i + ADDR_W'(off);
endmodule

// File: rtl/vec_gate_decode.sv
module vec_gate_decode
  import vec_lookup_pkg::*;
(
  input  logic [31:0] w0_i,
  input  logic [31:0] w1_i,
  output logic [15:0] sel_o,
  output logic [31:0] off_o,
  output gate_kind_e  kind_o,
  output logic        bad_o
);
  assign sel_o = w0_i[31:16];
  assign off_o = {w1_i[31:16], w0_i[15:0]};

  always_comb begin
    bad_o = 1'b0;
    unique case (w1_i[11:8])
      4'h5:        kind_o = GK_TASK;
      4'h6, 4'hE:  kind_o = GK_INT;
      4'h7, 4'hF:  kind_o = GK_TRAP;
      default: begin
        kind_o = GK_NONE;
        bad_o  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vec_gate_lookup.sv
module vec_gate_lookup
  import vec_lookup_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int VEC_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tbl_wr_i,
  input  logic [15:0]       tbl_word_i,
  input  logic              req_valid_i,
  input  logic [VEC_W-1:0]  req_vec_i,
  output logic              req_ready_o,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic              type_err_o,
  output logic              fault_o,
  output logic [VEC_W-1:0]  fault_vec_o,
  output logic [15:0]       gate_sel_o,
  output logic [31:0]       gate_off_o,
  output logic [1:0]        gate_kind_o
);
  localparam int WORD_BYTES = 4;

  lk_state_e         state_q;
  logic [ADDR_W-1:0] tbl_base, gen_addr, addr_q;
  logic [15:0]       tbl_limit;
  logic              gen_fault, bad_type;
  logic [VEC_W-1:0]  vec_q;
  logic [31:0]       w0_q, w1_q;
  gate_kind_e        kind;

  vec_tbl_reg #(.ADDR_W(ADDR_W), .WORD_W(16)) u_tbl (
    .clk_i, .rst_ni, .wr_i(tbl_wr_i), .word_i(tbl_word_i),
    .base_o(tbl_base), .limit_o(tbl_limit)
  );

  vec_addr_gen #(.ADDR_W(ADDR_W), .VEC_W(VEC_W), .LIM_W(16)) u_addr (
    .vec_i(req_vec_i), .base_i(tbl_base), .limit_i(tbl_limit),
    .addr_o(gen_addr), .fault_o(gen_fault)
  );

  vec_gate_decode u_dec (
    .w0_i(w0_q), .w1_i(w1_q), .sel_o(gate_sel_o), .off_o(gate_off_o),
    .kind_o(kind), .bad_o(bad_type)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      vec_q   <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          vec_q   <= req_vec_i;
          addr_q  <= gen_addr;
          state_q <= gen_fault ? ST_FLT : ST_A0;
        end
        ST_A0: if (mem_ready_i) state_q <= ST_D0;
        ST_D0: if (mem_rvalid_i) begin
          w0_q    <= mem_rdata_i;
          state_q <= ST_A1;
        end
        ST_A1: if (mem_ready_i) state_q <= ST_D1;
        ST_D1: if (mem_rvalid_i) begin
          w1_q    <= mem_rdata_i;
          state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = state_q == ST_IDLE;
  assign mem_valid_o = (state_q == ST_A0) || (state_q == ST_A1);
  assign mem_addr_o  = (state_q == ST_A1) ? addr_q + ADDR_W'(WORD_BYTES) : addr_q;
  assign done_o      = (state_q == ST_FIN) && !bad_type;
  assign type_err_o  = (state_q == ST_FIN) && bad_type;
  assign fault_o     = state_q == ST_FLT;
  assign fault_vec_o = vec_q;
  assign gate_kind_o = kind;

  // R6
  hs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o));
  // R11
  one_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, type_err_o, fault_o}));
  // R4
  fault_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_o) |-> $past(req_valid_i && req_ready_o));
  // R6
  fin_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o || type_err_o) |-> $past(mem_rvalid_i));
endmodule

// File: tb/tb_vec_gate_lookup.sv
module tb_vec_gate_lookup;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_wr = 1'b0;
  logic [15:0] tbl_word = '0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_vec = '0;
  logic        req_ready, mem_valid, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_rdata;
  logic        done, type_err, fault;
  logic [7:0]  fault_vec;
  logic [15:0] gate_sel;
  logic [31:0] gate_off;
  logic [1:0]  gate_kind;

  always #2 clk = ~clk;

  vec_gate_lookup dut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_wr_i(tbl_wr), .tbl_word_i(tbl_word),
    .req_valid_i(req_valid), .req_vec_i(req_vec), .req_ready_o(req_ready),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done),
    .type_err_o(type_err), .fault_o(fault), .fault_vec_o(fault_vec),
    .gate_sel_o(gate_sel), .gate_off_o(gate_off), .gate_kind_o(gate_kind)
  );

  int n_chk = 0, n_fail = 0;
  int gnt_dly = 0, rd_lat = 0, rd_cnt = 0, hs_bad = 0;
  logic [31:0] rd_log [0:15];
  logic [31:0] mem [logic [31:0]];

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_rd(logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  // memory responder
  initial begin
    mem_ready = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_valid) begin
        automatic logic [31:0] a = mem_addr;
        repeat (gnt_dly) begin
          @(negedge clk);
          if (!mem_valid || mem_addr !== a) hs_bad++;
        end
        mem_ready = 1'b1;
        rd_log[rd_cnt % 16] = a;
        rd_cnt++;
        @(negedge clk);
        mem_ready = 1'b0;
        repeat (rd_lat) @(negedge clk);
        mem_rvalid = 1'b1;
        mem_rdata  = mem_rd(a);
        @(negedge clk);
        mem_rvalid = 1'b0;
      end
    end
  end

  task automatic put_desc(logic [31:0] a, logic [15:0] sel, logic [31:0] off, logic [3:0] ty);
    mem[a]     = {sel, off[15:0]};
    mem[a + 4] = {off[31:16], 4'h8, ty, 8'h00};
  endtask

  task automatic load_tbl(logic [15:0] lim, logic [31:0] base);
    logic [15:0] w [3];
    w[0] = lim; w[1] = base[15:0]; w[2] = base[31:16];
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); tbl_wr = 1'b1; tbl_word = w[i];
    end
    @(negedge clk); tbl_wr = 1'b0;
  endtask

  // outcome: 0 done, 1 type error, 2 fault, 3 timeout
  task automatic run_req(logic [7:0] v, output int outcome);
    @(negedge clk);
    req_valid = 1'b1; req_vec = v;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11", "ready low while busy", {31'b0, req_ready}, 32'h0);
    outcome = 3;
    for (int i = 0; i < 200; i++) begin
      if (done || type_err || fault) begin
        chk("R11", "single result", {31'b0, $onehot0({done, type_err, fault})}, 32'h1);
        outcome = done ? 0 : (type_err ? 1 : 2);
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic good_lookup(string rq, logic [7:0] v, logic [31:0] base,
                             logic [15:0] sel, logic [31:0] off, logic [3:0] ty,
                             logic [1:0] kind);
    int oc, c0;
    logic [31:0] a;
    a = base + {21'b0, v, 3'b000};
    put_desc(a, sel, off, ty);
    c0 = rd_cnt;
    run_req(v, oc);
    chk(rq, "outcome done", oc, 0);
    chk("R3", "read count", rd_cnt - c0, 2);
    chk("R3", "first address", rd_log[c0 % 16], a);
    chk("R3", "second address", rd_log[(c0 + 1) % 16], a + 4);
    chk("R7", "selector", {16'b0, gate_sel}, {16'b0, sel});
    chk("R7", "offset", gate_off, off);
    chk("R8", "kind", {30'b0, gate_kind}, {30'b0, kind});
  endtask

  task automatic test_reset;
    int oc, c0;
    chk("R1", "req_ready", {31'b0, req_ready}, 32'h1);
    chk("R1", "mem_valid", {31'b0, mem_valid}, 32'h0);
    chk("R1", "results", {29'b0, done, type_err, fault}, 32'h0);
    c0 = rd_cnt;
    run_req(8'd0, oc);
    chk("R1", "vec 0 faults with reset limit", oc, 2);
    chk("R1", "no read", rd_cnt - c0, 0);
  endtask

  task automatic test_basic;
    load_tbl(16'h07FF, 32'h0001_0000);
    good_lookup("R3", 8'h40, 32'h0001_0000, 16'h0008, 32'h1234_5678, 4'hE, 2'd1);
    good_lookup("R5", 8'hFF, 32'h0001_0000, 16'h0010, 32'hCAFE_0100, 4'hF, 2'd2);
  endtask

  task automatic test_types;
    int oc;
    good_lookup("R10", 8'd3,  32'h0001_0000, 16'h0020, 32'h0000_1111, 4'h5, 2'd0);
    good_lookup("R10", 8'd0,  32'h0001_0000, 16'h0028, 32'h2222_0000, 4'h6, 2'd1);
    good_lookup("R8",  8'd31, 32'h0001_0000, 16'h0030, 32'h8000_0001, 4'h7, 2'd2);
    put_desc(32'h0001_0050, 16'h0038, 32'h0, 4'hC);
    run_req(8'd10, oc);
    chk("R9", "type C rejected", oc, 1);
    put_desc(32'h0001_0058, 16'h0038, 32'h0, 4'h0);
    run_req(8'd11, oc);
    chk("R9", "type 0 rejected", oc, 1);
    chk("R9", "done low after reject", {31'b0, done}, 32'h0);
  endtask

  task automatic test_limit;
    int oc, c0;
    load_tbl(16'h00FF, 32'h0001_0000);
    good_lookup("R5", 8'd31, 32'h0001_0000, 16'h0040, 32'h0BAD_F00D, 4'hE, 2'd1);
    c0 = rd_cnt;
    run_req(8'd32, oc);
    chk("R4", "vec 32 faults", oc, 2);
    chk("R4", "fault vector", {24'b0, fault_vec}, 32'd32);
    chk("R4", "no read on fault", rd_cnt - c0, 0);
    load_tbl(16'h0006, 32'h0001_0000);
    run_req(8'd0, oc);
    chk("R4", "limit 6 faults vec 0", oc, 2);
  endtask

  task automatic test_handshake;
    load_tbl(16'h07FF, 32'h0001_0000);
    gnt_dly = 3; rd_lat = 2; hs_bad = 0;
    good_lookup("R6", 8'h40, 32'h0001_0000, 16'h0048, 32'h7654_3210, 4'hF, 2'd2);
    chk("R6", "address held during wait", hs_bad, 0);
    gnt_dly = 0; rd_lat = 0;
  endtask

  task automatic test_reload;
    load_tbl(16'h07FF, 32'hABCD_1230);
    good_lookup("R2", 8'd1, 32'hABCD_1230, 16'h0050, 32'h0102_0304, 4'h6, 2'd1);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_types();
    test_limit();
    test_handshake();
    test_reload();
    report();
  end
endmodule